// File: doc/BRIEF.md
# Watchdog Timer Bank

This block holds one to three independent watchdog units behind one 32-bit register window. Each unit runs a 32-bit down-counter that advances on an external tick-enable input. Software keeps the system alive by writing a 16-bit key to the unit's restart register, which reloads the counter. If the counter runs out while the unit is enabled, the unit stops. It sets a sticky timeout flag and drives a reset-request pulse of programmable length.

Each unit owns a 0x20-byte slot. Unit k starts at byte address 0x20*k. Within a slot, the word at byte offset 0x00 shows the live count. The other words hold the reload value, the restart key, the control word, the timeout flag, the flag-clear strobe and the pulse width. Writes take effect on the clock edge of a single-cycle write strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `wdt_bank`

## Requirements
- R1: After reset, every unit has counter = reload = 0x03EF1480, control = 0, timeout flag = 0 and pulse width = 0x000000FF, and every `rst_req` bit is low.
- R2: Slot offsets are 0x00 count (read-only), 0x04 reload (read/write), 0x0C control (read/write, bit 0 = enable), 0x10 timeout flag in bit 0 (read-only) and 0x18 pulse width (read/write). `bus_rdata` shows the addressed word in the cycle after `bus_rd` and is 0 in any cycle that does not follow a read strobe.
- R3: A write to offset 0x08 whose bits [15:0] equal 0x4755 loads the counter from the reload register. A write there with any other low half leaves the counter unchanged.
- R4: A control write that sets bit 0 while bit 0 is clear loads the counter from reload and starts the countdown. A control write that leaves bit 0 set does not reload.
- R5: A control write that clears bit 0 stops the countdown, and the counter holds its value.
- R6: A key write while bit 0 is clear loads the counter but does not start counting.
- R7: While counting, each cycle with `tick` high lowers the counter by one. Ticks do nothing while the unit is stopped. A tick in the same cycle as a key or control write to that unit is dropped.
- R8: A tick that meets a counter of 1 or 0 while counting leaves the counter at 0, stops the unit and sets the timeout flag. A valid key write while bit 0 is set restarts counting.
- R9: Expiry raises that unit's `rst_req` bit for N clock cycles, starting the cycle after the expiring tick. N is bits [7:0] of the pulse width register, and a value of 0 gives one cycle.
- R10: A write of any value to offset 0x14 clears the timeout flag.
- R11: Reads of offsets 0x08, 0x14 and 0x1C, reads of addresses that are not 4-byte aligned and reads of slots at or beyond NUM_UNITS return 0. Writes to 0x00 or 0x10 and writes to addresses that are not aligned change nothing.
- R12: Units at stride 0x20 are independent. Accesses and ticks handled by one unit do not change another unit's registers or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Countdown enable, one step per high cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| rst_req | output | NUM_UNITS | Per-unit reset-request pulse |

## Verification
The countdown is driven in four ways: ticks while the unit is disabled, ticks after an enable edge, a redundant enable write during counting, and a disable in the middle of a count. Together these separate reload-on-edge from reload-on-any-write and show whether stopping really freezes the counter. Key writes with the wrong low half and with the right low half are compared to show that only the low 16 bits are decoded. Expiry is run with pulse width 3 and with pulse width 0, which checks both the programmed length and the one-cycle minimum. A second unit is counted while the first stays frozen, and a behavioural model checks every read and every `rst_req` bit on every cycle.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;

   localparam int          DATA_W      = 32;
   localparam int          SLOT_LG     = 5;          // 0x20-byte slot per unit
   localparam int          PULSE_W     = 8;
   localparam logic [15:0] KICK_KEY    = 16'h4755;
   localparam logic [31:0] COUNT_INIT  = 32'h03EF1480;
   localparam logic [31:0] WIDTH_INIT  = 32'h000000FF;

   // word index inside a slot (byte offset / 4)
   typedef enum logic [2:0] {
      RI_COUNT  = 3'd0,
      RI_RELOAD = 3'd1,
      RI_KICK   = 3'd2,
      RI_CTRL   = 3'd3,
      RI_TSTAT  = 3'd4,
      RI_TCLR   = 3'd5,
      RI_WIDTH  = 3'd6,
      RI_MASK   = 3'd7
   } reg_idx_e;

endpackage

// File: rtl/wdt_addr_dec.sv
module wdt_addr_dec
   import wdt_bank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_UNITS = 3
) (
   input  logic [ADDR_W-1:0]    addr,
   output reg_idx_e             reg_idx,
   output logic [1:0]           unit_idx,
   output logic [NUM_UNITS-1:0] unit_sel,
   output logic                 valid
);

   localparam int UFIELD_W = ADDR_W - SLOT_LG;

   logic [UFIELD_W-1:0] ufield;
   logic                aligned;

   assign ufield   = addr[ADDR_W-1:SLOT_LG];
   assign aligned  = (addr[1:0] == 2'b00);
   assign valid    = aligned && (ufield < UFIELD_W'(NUM_UNITS));
   assign reg_idx  = reg_idx_e'(addr[SLOT_LG-1:2]);
   assign unit_idx = ufield[1:0];

   for (genvar k = 0; k < NUM_UNITS; k++) begin : g_sel
      assign unit_sel[k] = valid && (ufield == UFIELD_W'(k));
   end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LEN_W-1:0] len,
   output logic             active
);

   logic [LEN_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (fire) begin
         remain_q <= (len == '0) ? LEN_W'(1) : len;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - LEN_W'(1);
      end
   end

   assign active = (remain_q != '0);

endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
   import wdt_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  reg_idx_e          reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] count_o,
   output logic [DATA_W-1:0] reload_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] width_o,
   output logic              run_o,
   output logic              tmo_o,
   output logic              expire_o
);

   logic [DATA_W-1:0] count_q, reload_q, ctrl_q, width_q;
   logic              run_q, tmo_q;
   logic              kick, ctrl_wr, step;

   assign kick     = wr_en && (reg_idx == RI_KICK) && (wdata[15:0] == KICK_KEY);
   assign ctrl_wr  = wr_en && (reg_idx == RI_CTRL);
   assign step     = run_q && tick && !kick && !ctrl_wr;
   assign expire_o = step && (count_q <= DATA_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= COUNT_INIT;
         run_q   <= 1'b0;
         ctrl_q  <= '0;
      end else if (kick) begin
         count_q <= reload_q;
         if (ctrl_q[0]) run_q <= 1'b1;
      end else if (ctrl_wr) begin
         ctrl_q <= wdata;
         if (wdata[0] && !ctrl_q[0]) begin
            count_q <= reload_q;
            run_q   <= 1'b1;
         end else if (!wdata[0]) begin
            run_q   <= 1'b0;
         end
      end else if (step) begin
         if (expire_o) begin
            count_q <= '0;
            run_q   <= 1'b0;
         end else begin
            count_q <= count_q - DATA_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= COUNT_INIT;
         width_q  <= WIDTH_INIT;
         tmo_q    <= 1'b0;
      end else begin
         if (wr_en && reg_idx == RI_RELOAD) reload_q <= wdata;
         if (wr_en && reg_idx == RI_WIDTH)  width_q  <= wdata;
         if (expire_o)                          tmo_q <= 1'b1;
         else if (wr_en && reg_idx == RI_TCLR)  tmo_q <= 1'b0;
      end
   end

   assign count_o  = count_q;
   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;
   assign width_o  = width_q;
   assign run_o    = run_q;
   assign tmo_o    = tmo_q;

endmodule

// File: rtl/wdt_bank.sv
module wdt_bank
   import wdt_bank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_UNITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_UNITS-1:0] rst_req
);

   if (NUM_UNITS < 1 || NUM_UNITS > 3) begin : g_bad_units
      $error("wdt_bank: NUM_UNITS must be 1..3");
   end
   if (ADDR_W < SLOT_LG + 2) begin : g_bad_addr
      $error("wdt_bank: ADDR_W too small for the slot window");
   end

   reg_idx_e                              reg_idx;
   logic [1:0]                            unit_idx;
   logic [NUM_UNITS-1:0]                  unit_sel;
   logic                                  acc_ok;

   logic [NUM_UNITS-1:0][DATA_W-1:0]      cnt_all, rel_all, ctl_all, wid_all;
   logic [NUM_UNITS-1:0]                  run_all, tmo_all, exp_all;

   wdt_addr_dec #(.ADDR_W(ADDR_W), .NUM_UNITS(NUM_UNITS)) u_dec (
      .addr     (bus_addr),
      .reg_idx  (reg_idx),
      .unit_idx (unit_idx),
      .unit_sel (unit_sel),
      .valid    (acc_ok)
   );

   for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
      wdt_unit u_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .wr_en    (bus_wr && unit_sel[k]),
         .reg_idx  (reg_idx),
         .wdata    (bus_wdata),
         .count_o  (cnt_all[k]),
         .reload_o (rel_all[k]),
         .ctrl_o   (ctl_all[k]),
         .width_o  (wid_all[k]),
         .run_o    (run_all[k]),
         .tmo_o    (tmo_all[k]),
         .expire_o (exp_all[k])
      );

      wdt_pulse #(.LEN_W(PULSE_W)) u_pulse (
         .clk    (clk),
         .rst_n  (rst_n),
         .fire   (exp_all[k]),
         .len    (wid_all[k][PULSE_W-1:0]),
         .active (rst_req[k])
      );
   end

   logic [DATA_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_UNITS; k++) begin
         if (acc_ok && unit_idx == 2'(k)) begin
            unique case (reg_idx)
               RI_COUNT:  rd_word = cnt_all[k];
               RI_RELOAD: rd_word = rel_all[k];
               RI_CTRL:   rd_word = ctl_all[k];
               RI_TSTAT:  rd_word = {{(DATA_W-1){1'b0}}, tmo_all[k]};
               RI_WIDTH:  rd_word = wid_all[k];
               default:   rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       bus_rdata <= '0;
      else if (bus_rd)  bus_rdata <= rd_word;
      else              bus_rdata <= '0;
   end

endmodule

// File: rtl/wdt_bank_chk.sv
module wdt_bank_chk #(
   parameter int ADDR_W    = 12,
   parameter int NUM_UNITS = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        bus_wr,
   input logic                        bus_rd,
   input logic [31:0]                 bus_rdata,
   input logic [NUM_UNITS-1:0]        rst_req,
   input logic [NUM_UNITS-1:0][31:0]  cnt_all,
   input logic [NUM_UNITS-1:0][31:0]  ctl_all,
   input logic [NUM_UNITS-1:0]        run_all,
   input logic [NUM_UNITS-1:0]        tmo_all
);

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 32'd0); // R2

   AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == 32'd0); // R11

   for (genvar k = 0; k < NUM_UNITS; k++) begin : g_chk
      logic touched;
      assign touched = bus_wr && (bus_addr[1:0] == 2'b00)
                       && (bus_addr[ADDR_W-1:5] == (ADDR_W-5)'(k));

      AST_RUN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !ctl_all[k][0] |-> !run_all[k]); // R5

      AST_TICK_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         (run_all[k] && tick && !touched)
         |=> (cnt_all[k] == $past(cnt_all[k]) - 32'd1) || (cnt_all[k] == 32'd0)); // R7

      AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         ((!run_all[k] || !tick) && !touched) |=> $stable(cnt_all[k])); // R6

      AST_EXPIRY_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tmo_all[k]) |-> (rst_req[k] && !run_all[k])); // R8
   end

endmodule

bind wdt_bank wdt_bank_chk #(.ADDR_W(ADDR_W), .NUM_UNITS(NUM_UNITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .rst_req   (rst_req),
   .cnt_all   (cnt_all),
   .ctl_all   (ctl_all),
   .run_all   (run_all),
   .tmo_all   (tmo_all)
);

// File: tb/wdt_bank_test.sv
module wdt_bank_test;

   localparam int AW = 12;
   localparam int NU = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NU-1:0] rst_req;

   int    errors = 0;
   int    checks = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;   // 50 MHz

   wdt_bank #(.ADDR_W(AW), .NUM_UNITS(NU)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rst_req(rst_req)
   );

   // ---------------- behavioural reference model ----------------
   longint m_cnt[NU], m_rel[NU], m_ctl[NU], m_wid[NU];
   bit     m_run[NU], m_tmo[NU];
   int     m_pc[NU];
   longint m_rd;

   function automatic longint mreg(int u, int off);
      case (off)
         0:  return m_cnt[u];
         4:  return m_rel[u];
         12: return m_ctl[u];
         16: return longint'(m_tmo[u]);
         24: return m_wid[u];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NU; k++) begin
            m_cnt[k] = 64'h03EF1480; m_rel[k] = 64'h03EF1480;
            m_ctl[k] = 0; m_wid[k] = 255; m_run[k] = 0; m_tmo[k] = 0; m_pc[k] = 0;
         end
         m_rd = 0;
      end else begin
         int  u, off;
         bit  al, inr;
         al  = (bus_addr % 4) == 0;
         u   = int'(bus_addr) / 32;
         off = int'(bus_addr) % 32;
         inr = u < NU;
         m_rd = (bus_rd && al && inr) ? mreg(u, off) : 0;
         for (int k = 0; k < NU; k++) begin
            bit hit, ex;
            hit = bus_wr && al && inr && (u == k);
            ex  = 0;
            if (m_pc[k] > 0) m_pc[k]--;
            if (hit && off == 8 && bus_wdata[15:0] == 16'h4755) begin
               m_cnt[k] = m_rel[k];
               if (m_ctl[k] % 2 == 1) m_run[k] = 1;
            end else if (hit && off == 12) begin
               if (bus_wdata[0] && (m_ctl[k] % 2 == 0)) begin
                  m_cnt[k] = m_rel[k]; m_run[k] = 1;
               end
               if (!bus_wdata[0]) m_run[k] = 0;
               m_ctl[k] = bus_wdata;
            end else if (m_run[k] && tick) begin
               if (m_cnt[k] <= 1) begin m_cnt[k] = 0; m_run[k] = 0; ex = 1; end
               else m_cnt[k]--;
            end
            if (ex) begin
               m_tmo[k] = 1;
               m_pc[k]  = (m_wid[k] % 256 == 0) ? 1 : int'(m_wid[k] % 256);
            end else if (hit && off == 20) m_tmo[k] = 0;
            if (hit && off == 4)  m_rel[k] = bus_wdata;
            if (hit && off == 24) m_wid[k] = bus_wdata;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (bus_rdata !== 32'(m_rd)) begin
            errors++;
            $display("FAIL %s model: bus_rdata actual=%h expected=%h", cur_req, bus_rdata, 32'(m_rd));
         end
         for (int k = 0; k < NU; k++) begin
            checks++;
            if (rst_req[k] !== (m_pc[k] > 0)) begin
               errors++;
               $display("FAIL %s model: rst_req[%0d] actual=%b expected=%b",
                        cur_req, k, rst_req[k], m_pc[k] > 0);
            end
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
      @(negedge clk); bus_addr = AW'(a); bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s read %h: actual=%h expected=%h", req, a, bus_rdata, exp);
      end
   endtask

   task automatic ticks(input int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic pulse_chk(input int unit, input int exp, input string req);
      int c = 0;
      for (int i = 0; i < 12; i++) begin
         if (rst_req[unit]) c++;
         @(negedge clk);
      end
      checks++;
      if (c != exp) begin
         errors++;
         $display("FAIL %s pulse length: actual=%0d expected=%0d", req, c, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      for (int k = 0; k < NU; k++) begin
         rd_chk(32*k + 0,  32'h03EF1480, "R1");
         rd_chk(32*k + 4,  32'h03EF1480, "R1");
         rd_chk(32*k + 12, 32'h0, "R1");
         rd_chk(32*k + 16, 32'h0, "R1");
         rd_chk(32*k + 24, 32'h000000FF, "R1");
      end

      // R2 / R3 reload and key
      cur_req = "R3";
      wr(4, 32'd5);
      rd_chk(4, 32'd5, "R2");
      rd_chk(0, 32'h03EF1480, "R3");
      wr(8, 32'h12344756);
      rd_chk(0, 32'h03EF1480, "R3");
      wr(8, 32'hABCD4755);
      rd_chk(0, 32'd5, "R3");

      // R6 restart while disabled does not count
      cur_req = "R6";
      wr(4, 32'd9);
      wr(8, 32'h00004755);
      ticks(4);
      rd_chk(0, 32'd9, "R6");
      wr(4, 32'd5);

      // R4 enable edge loads and counts
      cur_req = "R4";
      wr(12, 32'h1);
      rd_chk(0, 32'd5, "R4");
      ticks(2);
      rd_chk(0, 32'd3, "R7");
      wr(12, 32'h1);
      rd_chk(0, 32'd3, "R4");
      rd_chk(12, 32'h1, "R2");

      // R5 disable freezes
      cur_req = "R5";
      wr(12, 32'h0);
      ticks(3);
      rd_chk(0, 32'd3, "R5");

      // R8 / R9 expiry with width 3
      cur_req = "R9";
      wr(24, 32'h00000103);
      wr(12, 32'h1);
      ticks(5);
      pulse_chk(0, 3, "R9");
      rd_chk(0, 32'd0, "R8");
      rd_chk(16, 32'd1, "R8");
      ticks(2);
      rd_chk(0, 32'd0, "R8");

      // R10 clear flag
      cur_req = "R10";
      wr(20, 32'hDEADBEEF);
      rd_chk(16, 32'd0, "R10");

      // R9 width 0 gives one cycle; R8 restart after expiry
      cur_req = "R8";
      wr(24, 32'h0);
      wr(8, 32'h00004755);
      ticks(2);
      rd_chk(0, 32'd3, "R8");
      ticks(3);
      pulse_chk(0, 1, "R9");
      rd_chk(16, 32'd1, "R8");

      // R12 independent units
      cur_req = "R12";
      wr(32 + 4, 32'd7);
      wr(32 + 12, 32'h1);
      ticks(3);
      rd_chk(32 + 0, 32'd4, "R12");
      rd_chk(0, 32'd0, "R12");
      rd_chk(64 + 4, 32'h03EF1480, "R12");
      rd_chk(16, 32'd1, "R12");

      // R11 reserved, misaligned and out-of-range accesses
      cur_req = "R11";
      rd_chk(8, 32'd0, "R11");
      rd_chk(20, 32'd0, "R11");
      rd_chk(28, 32'd0, "R11");
      rd_chk(96 + 4, 32'd0, "R11");
      rd_chk(5, 32'd0, "R11");
      wr(0, 32'h1234);
      rd_chk(0, 32'd0, "R11");
      wr(6, 32'h99);
      rd_chk(4, 32'd5, "R11");
      wr(16, 32'h0);
      rd_chk(16, 32'd1, "R11");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule